// File: doc/BRIEF.md
# Accumulator Overflow Status Flags

This unit keeps the overflow status of two wide signed accumulators, A and B, which hold 72 bits by default with the top bit as the sign. Each time the datapath writes an accumulator, it hands this unit the new value, a strobe saying that the result was saturated, and a strobe saying that the result carried into the sign bit. From these the unit keeps two flags per accumulator. The first is a live range flag. It shows whether the stored value still fits in a 1.31 fractional word, that is, whether every bit from the sign bit down to bit 31 is a copy of the sign. The second is a sticky flag that records a saturation or sign-overflow event until software clears it.

Two summary outputs report whether either accumulator has its range flag set, and whether either has its sticky flag set. Software can overwrite all four per-accumulator flags in one cycle through a small write port. The summary outputs follow from their sources and cannot be written. The unit has no arithmetic of its own.

Each accumulator owns two small state machines. The range machine has states `LIVE_IN` and `LIVE_OUT`. Its transitions are `T_RANGE_EXIT` (to `LIVE_OUT`, on an out-of-range accumulator write or a software write of 1) and `T_RANGE_ENTER` (to `LIVE_IN`, on an in-range accumulator write or a software write of 0). The sticky machine has states `STK_CLEAR` and `STK_HELD`. Its transitions are `T_SET_HW` (hardware event), `T_SET_SW` (software write of 1) and `T_CLR_SW` (software write of 0 with no hardware event in the same cycle).

Top module: `acc_status_flags`

## Requirements
- R1: After reset, the range flags, the sticky flags and both summary outputs are all 0.
- R2: On an accumulator write, that accumulator's range flag takes the value 1 if bits [ACC_W-1 : FRAC_W-1] of the written value are not all equal, and 0 if they are all equal. With the default widths this covers bits 71 down to 31. The new flag value appears on the clock edge that takes the write.
- R3: A range flag keeps its value in any cycle that has neither a write to its accumulator nor a software write.
- R4: An accumulator write with its saturation strobe high sets that accumulator's sticky flag. Saturation and overflow strobes have no effect in a cycle without an accumulator write.
- R5: An accumulator write with its sign-overflow strobe high sets the sticky flag only while that accumulator's saturation-enable input is low. While saturation-enable is high, the sign-overflow strobe has no effect.
- R6: A sticky flag stays at 1 until a software write clears it. Later in-range accumulator writes do not clear it.
- R7: A software write loads all four flags from `sw_wdata`: bit 0 into range A, bit 1 into range B, bit 2 into sticky A, bit 3 into sticky B. A value of 1 sets a flag and 0 clears it.
- R8: When a software write and hardware activity land in the same cycle, hardware wins. An accumulator write decides that accumulator's range flag, and a hardware sticky event leaves the sticky flag at 1.
- R9: `frac_any` equals range A OR range B in every cycle.
- R10: `sticky_any` equals sticky A OR sticky B in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_a_wr | input | 1 | Accumulator A is written this cycle |
| acc_a_val | input | ACC_W | New value of accumulator A |
| acc_a_sat | input | 1 | Result written to A was saturated |
| acc_a_ovf | input | 1 | Result written to A overflowed into the sign bit |
| acc_a_sat_en | input | 1 | Saturation mode is enabled for A |
| acc_b_wr | input | 1 | Accumulator B is written this cycle |
| acc_b_val | input | ACC_W | New value of accumulator B |
| acc_b_sat | input | 1 | Result written to B was saturated |
| acc_b_ovf | input | 1 | Result written to B overflowed into the sign bit |
| acc_b_sat_en | input | 1 | Saturation mode is enabled for B |
| sw_wr | input | 1 | Software flag write strobe |
| sw_wdata | input | 4 | Flag values written by software (field layout in R7) |
| frac_a | output | 1 | Range flag of A |
| frac_b | output | 1 | Range flag of B |
| sticky_a | output | 1 | Sticky flag of A |
| sticky_b | output | 1 | Sticky flag of B |
| frac_any | output | 1 | Either range flag is set |
| sticky_any | output | 1 | Either sticky flag is set |

## Verification
The in-module properties watch the per-cycle rules on every clock. These are: the range flag follows the guard comparison after each accumulator write, the range flag holds when nothing writes it, a hardware event always leaves the sticky flag set even against a software clear, and a held sticky flag survives anything except a software clear. Whether the range threshold sits at the right bit is a different matter. That is shown only by the bench sweeping every value of a narrow accumulator against an arithmetic range test. The bench also covers the field order of the software write, the gating of the overflow strobe by saturation-enable, and the summary outputs, by walking every combination of strobes, enables and write data.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

    // number of accumulators tracked
    localparam int NUM_ACC = 2;

    // software write field positions
    localparam int SW_FRAC_LSB   = 0;
    localparam int SW_STICKY_LSB = NUM_ACC;
    localparam int SW_W          = 2 * NUM_ACC;

    typedef enum logic {
        LIVE_IN  = 1'b0,
        LIVE_OUT = 1'b1
    } live_state_t;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_HELD  = 1'b1
    } stk_state_t;

endpackage

// File: rtl/acc_guard_chk.sv
module acc_guard_chk #(
    parameter int ACC_W  = 72,
    parameter int FRAC_W = 32
) (
    input  logic [ACC_W-1:0] value,
    output logic             out_of_range
);
    // guard span: sign bit down to the fractional sign position
    localparam int GUARD_LSB = FRAC_W - 1;
    localparam int GUARD_W   = ACC_W - GUARD_LSB;

    logic [GUARD_W-1:0] guard;

    always_comb begin
        guard        = value[ACC_W-1:GUARD_LSB];
        out_of_range = !((&guard) || !(|guard));
    end

endmodule

// File: rtl/acc_flag_slice.sv
module acc_flag_slice
    import acc_flag_pkg::*;
#(
    parameter int ACC_W  = 72,
    parameter int FRAC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  logic [ACC_W-1:0] acc_val,
    input  logic             sat_evt,
    input  logic             ovf_evt,
    input  logic             sat_en,
    input  logic             sw_wr,
    input  logic             sw_frac,
    input  logic             sw_sticky,
    output logic             frac_flag,
    output logic             sticky_flag
);

    live_state_t live_q, live_d;
    stk_state_t  stk_q,  stk_d;
    logic        oor;
    logic        hw_set;

    acc_guard_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_guard (
        .value        (acc_val),
        .out_of_range (oor)
    );

    assign hw_set = acc_wr && (sat_evt || (ovf_evt && !sat_en));

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= LIVE_IN;
            stk_q  <= STK_CLEAR;
        end else begin
            live_q <= live_d;
            stk_q  <= stk_d;
        end
    end

    // range machine: accumulator write has priority over software
    always_comb begin
        live_d = live_q;
        unique case (live_q)
            LIVE_IN: begin
                // T_RANGE_EXIT
                if ((acc_wr && oor) || (!acc_wr && sw_wr && sw_frac))
                    live_d = LIVE_OUT;
            end
            LIVE_OUT: begin
                // T_RANGE_ENTER
                if ((acc_wr && !oor) || (!acc_wr && sw_wr && !sw_frac))
                    live_d = LIVE_IN;
            end
        endcase
    end

    // sticky machine: hardware set beats software clear
    always_comb begin
        stk_d = stk_q;
        unique case (stk_q)
            STK_CLEAR: begin
                if (hw_set)                 stk_d = STK_HELD;  // T_SET_HW
                else if (sw_wr && sw_sticky) stk_d = STK_HELD; // T_SET_SW
            end
            STK_HELD: begin
                if (!hw_set && sw_wr && !sw_sticky)
                    stk_d = STK_CLEAR;                         // T_CLR_SW
            end
        endcase
    end

    // outputs
    always_comb begin
        frac_flag   = (live_q == LIVE_OUT);
        sticky_flag = (stk_q == STK_HELD);
    end

    // R2: range flag follows the guard test after an accumulator write
    p_live_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (frac_flag == $past(oor)));

    // R3: range flag holds when nothing writes it
    p_live_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && !sw_wr) |=> $stable(frac_flag));

    // R8: a hardware event always leaves the sticky flag set
    p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && (sat_evt || (ovf_evt && !sat_en))) |=> sticky_flag);

    // R6: a held sticky flag only falls on a software clear
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_flag && !(sw_wr && !sw_sticky)) |=> sticky_flag);

    // R5: sign overflow alone under saturation mode does not raise the flag
    p_ovf_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_flag && acc_wr && ovf_evt && sat_en && !sat_evt && !sw_wr)
        |=> !sticky_flag);

endmodule

// File: rtl/acc_status_flags.sv
module acc_status_flags
    import acc_flag_pkg::*;
#(
    parameter int ACC_W  = 72,
    parameter int FRAC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_a_wr,
    input  logic [ACC_W-1:0] acc_a_val,
    input  logic             acc_a_sat,
    input  logic             acc_a_ovf,
    input  logic             acc_a_sat_en,
    input  logic             acc_b_wr,
    input  logic [ACC_W-1:0] acc_b_val,
    input  logic             acc_b_sat,
    input  logic             acc_b_ovf,
    input  logic             acc_b_sat_en,
    input  logic             sw_wr,
    input  logic [3:0]       sw_wdata,
    output logic             frac_a,
    output logic             frac_b,
    output logic             sticky_a,
    output logic             sticky_b,
    output logic             frac_any,
    output logic             sticky_any
);

    logic             wr_v   [NUM_ACC];
    logic [ACC_W-1:0] val_v  [NUM_ACC];
    logic             sat_v  [NUM_ACC];
    logic             ovf_v  [NUM_ACC];
    logic             sen_v  [NUM_ACC];
    logic [NUM_ACC-1:0] frac_vec;
    logic [NUM_ACC-1:0] stk_vec;
    logic [SW_W-1:0]    wdata;

    assign wdata = sw_wdata;

    assign wr_v[0]  = acc_a_wr;
    assign val_v[0] = acc_a_val;
    assign sat_v[0] = acc_a_sat;
    assign ovf_v[0] = acc_a_ovf;
    assign sen_v[0] = acc_a_sat_en;
    assign wr_v[1]  = acc_b_wr;
    assign val_v[1] = acc_b_val;
    assign sat_v[1] = acc_b_sat;
    assign ovf_v[1] = acc_b_ovf;
    assign sen_v[1] = acc_b_sat_en;

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        acc_flag_slice #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_wr      (wr_v[g]),
            .acc_val     (val_v[g]),
            .sat_evt     (sat_v[g]),
            .ovf_evt     (ovf_v[g]),
            .sat_en      (sen_v[g]),
            .sw_wr       (sw_wr),
            .sw_frac     (wdata[SW_FRAC_LSB + g]),
            .sw_sticky   (wdata[SW_STICKY_LSB + g]),
            .frac_flag   (frac_vec[g]),
            .sticky_flag (stk_vec[g])
        );
    end

    always_comb begin
        frac_a     = frac_vec[0];
        frac_b     = frac_vec[1];
        sticky_a   = stk_vec[0];
        sticky_b   = stk_vec[1];
        frac_any   = |frac_vec;
        sticky_any = |stk_vec;
    end

    // R1: nothing is flagged in the first cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !(frac_any || sticky_any));

endmodule

// File: tb/sim_acc_status_flags.sv
module sim_acc_status_flags;

    localparam int AW = 8;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_wr = 0, a_sat = 0, a_ovf = 0, a_sen = 0;
    logic          b_wr = 0, b_sat = 0, b_ovf = 0, b_sen = 0;
    logic [AW-1:0] a_val = '0, b_val = '0;
    logic          sw_wr = 0;
    logic [3:0]    sw_wdata = '0;
    logic          frac_a, frac_b, sticky_a, sticky_b, frac_any, sticky_any;

    int  nvec = 0;
    int  nfail = 0;
    bit  done = 0;

    // bench model state
    bit  m_fa = 0, m_fb = 0, m_sa = 0, m_sb = 0;

    always #5 clk = ~clk;

    acc_status_flags #(.ACC_W(AW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_a_wr(a_wr), .acc_a_val(a_val), .acc_a_sat(a_sat),
        .acc_a_ovf(a_ovf), .acc_a_sat_en(a_sen),
        .acc_b_wr(b_wr), .acc_b_val(b_val), .acc_b_sat(b_sat),
        .acc_b_ovf(b_ovf), .acc_b_sat_en(b_sen),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .frac_a(frac_a), .frac_b(frac_b), .sticky_a(sticky_a),
        .sticky_b(sticky_b), .frac_any(frac_any), .sticky_any(sticky_any)
    );

    // arithmetic range test: fits in FW-bit signed fraction word
    function automatic bit out_rng(logic [AW-1:0] v);
        int s;
        s = int'($signed(v));
        return (s < -(1 << (FW-1))) || (s > (1 << (FW-1)) - 1);
    endfunction

    task automatic chk(string what, string req, bit act, bit exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0b want %0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        a_wr = 0; a_sat = 0; a_ovf = 0; a_sen = 0;
        b_wr = 0; b_sat = 0; b_ovf = 0; b_sen = 0;
        sw_wr = 0; sw_wdata = '0;
    endtask

    task automatic check_all(string rfa, string rfb, string rsa, string rsb);
        chk("frac_a", rfa, frac_a, m_fa);
        chk("frac_b", rfb, frac_b, m_fb);
        chk("sticky_a", rsa, sticky_a, m_sa);
        chk("sticky_b", rsb, sticky_b, m_sb);
        chk("frac_any", "R9", frac_any, m_fa | m_fb);
        chk("sticky_any", "R10", sticky_any, m_sa | m_sb);
    endtask

    function automatic string frac_tag(bit wr, bit sw);
        if (wr && sw) return "R8";
        if (wr)       return "R2";
        if (sw)       return "R7";
        return "R3";
    endfunction

    function automatic string stk_tag(bit wr, bit sat, bit ovf, bit sen, bit sw);
        bit hw;
        hw = wr && (sat || (ovf && !sen));
        if (hw && sw)           return "R8";
        if (wr && sat)          return "R4";
        if (wr && ovf)          return "R5";
        if (!wr && (sat || ovf)) return "R4";
        if (sw)                 return "R7";
        return "R6";
    endfunction

    initial begin
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: all flags clear after reset
        check_all("R1", "R1", "R1", "R1");

        // R2 sweep: every value of A, then of B
        for (int v = 0; v < (1 << AW); v++) begin
            idle();
            a_wr = 1; a_val = AW'(v);
            tick();
            m_fa = out_rng(AW'(v));
            check_all("R2", "R3", "R6", "R6");
        end
        for (int v = 0; v < (1 << AW); v++) begin
            idle();
            b_wr = 1; b_val = AW'(v);
            tick();
            m_fb = out_rng(AW'(v));
            check_all("R3", "R2", "R6", "R6");
        end

        // every combination of strobes, enables and software data
        for (int i = 0; i < (1 << 13); i++) begin
            logic [AW-1:0] va, vb;
            bit hwa, hwb;
            va = AW'(i * 37 + (i >> 3));
            vb = AW'(i * 91 + 5);
            idle();
            a_wr = i[0]; a_sat = i[1]; a_ovf = i[2]; a_sen = i[3];
            b_wr = i[4]; b_sat = i[5]; b_ovf = i[6]; b_sen = i[7];
            sw_wr = i[8]; sw_wdata = 4'(i >> 9);
            a_val = va; b_val = vb;
            tick();
            if (a_wr) m_fa = out_rng(va); else if (sw_wr) m_fa = sw_wdata[0];
            if (b_wr) m_fb = out_rng(vb); else if (sw_wr) m_fb = sw_wdata[1];
            hwa = a_wr && (a_sat || (a_ovf && !a_sen));
            hwb = b_wr && (b_sat || (b_ovf && !b_sen));
            if (hwa) m_sa = 1; else if (sw_wr) m_sa = sw_wdata[2];
            if (hwb) m_sb = 1; else if (sw_wr) m_sb = sw_wdata[3];
            check_all(frac_tag(a_wr, sw_wr), frac_tag(b_wr, sw_wr),
                      stk_tag(a_wr, a_sat, a_ovf, a_sen, sw_wr),
                      stk_tag(b_wr, b_sat, b_ovf, b_sen, sw_wr));
        end

        // R6: set, then in-range writes must not clear
        idle(); a_wr = 1; a_sat = 1; a_val = '0; tick();
        m_sa = 1; m_fa = 0;
        idle(); a_wr = 1; a_val = AW'(3); tick();
        check_all("R2", "R3", "R6", "R6");
        idle(); tick();
        check_all("R3", "R3", "R6", "R6");

        idle();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: got timeout want completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule